// File: doc/BRIEF.md
# Indirect DSP Memory Access Port

This bridge gives a 32-bit bus master a narrow register window into the program and data memories of several DSP cores. For each core there is a word-address pointer and two access windows: one moves 32-bit program words, the other moves 16-bit data words. The host loads the pointer once, then reads or writes a window. Each successful access moves exactly one word and steps the pointer forward by one, so a block copy is a single pointer write followed by repeated accesses to the same window.

Program space holds the word addresses below a fixed base (0x4000 by default). Data space holds the addresses at and above it. A window used against the wrong space does not reach memory. It sets a sticky fault bit and records the pointer value. Memory reads have a fixed two-cycle latency, and the host bus waits for the data before it completes.

The controller is a four-state machine shared by all ports:
- `ST_IDLE` decodes a request. It goes to `ST_WAIT1` on a valid window read and to `ST_ACK` on anything else.
- `ST_WAIT1` always goes to `ST_WAIT2`.
- `ST_WAIT2` captures the memory data, advances the pointer and goes to `ST_ACK`.
- `ST_ACK` raises the one-cycle bus completion and returns to `ST_IDLE`.

Top module: `idma_bridge`

## Requirements
- R1: After reset `bus_ready` and every `mem_req` bit are 0, and every pointer, fault status and fault address register reads 0.
- R2: Port n occupies byte offsets n*0x10 + {0x0 pointer, 0x4 program window, 0x8 data window}. Its fault status register is at 0x20 + n*8 and its fault address register at 0x24 + n*8. A pointer write reads back unchanged.
- R3: A program-window write with the pointer below 0x4000 pulses that port's `mem_req` with `mem_we`=1, `mem_addr` = pointer and `mem_wdata` = the full 32-bit write data. A program-window read returns the stored 32-bit word.
- R4: A data-window write with the pointer at or above 0x4000 drives `mem_wdata` with bits 15:0 of the write data and zeros in bits 31:16.
- R5: Counting the cycle in which `ST_IDLE` takes the request as cycle 1, `bus_ready` is high for exactly one cycle. It rises in cycle 4 for a valid window read and in cycle 2 for every other access.
- R6: A data-window read returns the 16-bit memory word zero-extended to 32 bits.
- R7: Every successful window access adds one to that port's pointer, modulo 2^AW. The pointer 0xFFFF steps to 0x0000.
- R8: A program-window access at a pointer at or above 0x4000 sets status bit 0. A data-window access at a pointer below 0x4000 sets status bit 1. In both cases no `mem_req` is raised, the pointer does not change, a read returns 0 and the fault address register takes the pointer value.
- R9: Fault status bits stay set until a 1 is written to that bit position. Writes to the fault address register are ignored.
- R10: An access through one port never changes another port's pointer, and at most one `mem_req` bit is high at a time.
- R11: Offsets outside the map read 0 and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Host request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BAW (6) | Byte offset into the register window |
| bus_wdata | input | 32 | Host write data |
| bus_ready | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| mem_req | output | NPORT (2) | Per-port memory strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW (16) | Memory word address (program or data space) |
| mem_wdata | output | PW (32) | Memory write data |
| mem_rdata | input | NPORT*PW (64) | Per-port read data, valid two cycles after the strobe |

## Verification
The bench builds the default configuration: two ports, a 16-bit pointer and a space boundary at 0x4000. Each port is backed by a pair of 64-word behavioural RAMs that are indexed by the low six address bits. This size lets the bench sweep both ports and both windows across the space boundary (0x3FFC to 0x4007). It also reaches the pointer wrap at 0xFFFF. Expected words are computed arithmetically from the port and word index. Latency is counted in cycles for every access.

// File: rtl/idma_pkg.sv
package idma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT1,
        ST_WAIT2,
        ST_ACK
    } idma_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_PTR,
        K_PROG,
        K_DATA,
        K_FSTAT,
        K_FADDR
    } idma_kind_e;

endpackage

// File: rtl/idma_decode.sv
module idma_decode
    import idma_pkg::*;
#(
    parameter int NPORT       = 2,
    parameter int BAW         = 6,
    parameter int PORT_STRIDE = 16,
    parameter int FLT_BASE    = 32,
    parameter int FLT_STRIDE  = 8,
    localparam int PSW        = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [BAW-1:0] off,
    output idma_kind_e     kind,
    output logic [PSW-1:0] port
);

    always_comb begin
        kind = K_NONE;
        port = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (off == BAW'(p * PORT_STRIDE)) begin
                kind = K_PTR;   port = PSW'(p);
            end else if (off == BAW'(p * PORT_STRIDE + 4)) begin
                kind = K_PROG;  port = PSW'(p);
            end else if (off == BAW'(p * PORT_STRIDE + 8)) begin
                kind = K_DATA;  port = PSW'(p);
            end else if (off == BAW'(FLT_BASE + p * FLT_STRIDE)) begin
                kind = K_FSTAT; port = PSW'(p);
            end else if (off == BAW'(FLT_BASE + p * FLT_STRIDE + 4)) begin
                kind = K_FADDR; port = PSW'(p);
            end
        end
    end

endmodule

// File: rtl/idma_port_ctx.sv
module idma_port_ctx #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_wr,
    input  logic [AW-1:0] ptr_wdata,
    input  logic          advance,
    input  logic          fault,
    input  logic [1:0]    fault_bits,
    input  logic [1:0]    clr_bits,
    output logic [AW-1:0] ptr_q,
    output logic [1:0]    flt_stat,
    output logic [AW-1:0] flt_addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            flt_stat <= '0;
            flt_addr <= '0;
        end else begin
            if (ptr_wr)
                ptr_q <= ptr_wdata;
            else if (advance)
                ptr_q <= ptr_q + 1'b1;
            flt_stat <= (flt_stat & ~clr_bits) | (fault ? fault_bits : 2'b00);
            if (fault)
                flt_addr <= ptr_q;
        end
    end

    // R8: a faulting access never also advances the pointer
    a_r8_fault_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !advance);

    // R9: a status bit only falls when software clears it
    a_r9_sticky0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flt_stat[0]) |-> $past(clr_bits[0]));
    a_r9_sticky1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flt_stat[1]) |-> $past(clr_bits[1]));

endmodule

// File: rtl/idma_bridge.sv
module idma_bridge
    import idma_pkg::*;
#(
    parameter int NPORT       = 2,
    parameter int AW          = 16,
    parameter int PW          = 32,
    parameter int DW          = 16,
    parameter int BAW         = 6,
    parameter int DATA_BASE   = 'h4000,
    parameter int PORT_STRIDE = 16,
    parameter int FLT_BASE    = 32,
    parameter int FLT_STRIDE  = 8,
    localparam int PSW        = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [BAW-1:0]      bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic                bus_ready,
    output logic [31:0]         bus_rdata,
    output logic [NPORT-1:0]    mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [PW-1:0]       mem_wdata,
    input  logic [NPORT*PW-1:0] mem_rdata
);

    idma_state_e    state, nxt;
    idma_kind_e     dec_kind;
    logic [PSW-1:0] dec_port, sel_q;
    logic           sel_data_q, sel_data_n;
    logic [31:0]    rdata_q, rd_next;
    logic           load_rd;
    logic           in_data;

    logic [AW-1:0]    ptr_a   [NPORT];
    logic [1:0]       fstat_a [NPORT];
    logic [AW-1:0]    faddr_a [NPORT];
    logic [NPORT-1:0] ptr_wr_v, adv_v, fault_v;
    logic [1:0]       fault_bits;
    logic [1:0]       clr_v   [NPORT];

    idma_decode #(
        .NPORT(NPORT), .BAW(BAW), .PORT_STRIDE(PORT_STRIDE),
        .FLT_BASE(FLT_BASE), .FLT_STRIDE(FLT_STRIDE)
    ) u_dec (
        .off(bus_addr), .kind(dec_kind), .port(dec_port)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        idma_port_ctx #(.AW(AW)) u_ctx (
            .clk(clk), .rst_n(rst_n),
            .ptr_wr(ptr_wr_v[g]), .ptr_wdata(bus_wdata[AW-1:0]),
            .advance(adv_v[g]), .fault(fault_v[g]), .fault_bits(fault_bits),
            .clr_bits(clr_v[g]),
            .ptr_q(ptr_a[g]), .flt_stat(fstat_a[g]), .flt_addr(faddr_a[g])
        );
    end

    assign in_data = (ptr_a[dec_port] >= AW'(DATA_BASE));

    // state register and captured request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sel_q      <= '0;
            sel_data_q <= 1'b0;
            rdata_q    <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                sel_q      <= dec_port;
                sel_data_q <= sel_data_n;
            end
            if (load_rd)
                rdata_q <= rd_next;
        end
    end

    // next state and all control outputs
    always_comb begin
        nxt        = state;
        bus_ready  = 1'b0;
        mem_req    = '0;
        mem_we     = 1'b0;
        mem_addr   = ptr_a[dec_port];
        mem_wdata  = bus_wdata[PW-1:0];
        ptr_wr_v   = '0;
        adv_v      = '0;
        fault_v    = '0;
        fault_bits = 2'b00;
        for (int p = 0; p < NPORT; p++) clr_v[p] = 2'b00;
        load_rd    = 1'b0;
        rd_next    = '0;
        sel_data_n = 1'b0;
        unique case (state)
            ST_IDLE: if (bus_req) begin
                nxt     = ST_ACK;
                load_rd = !bus_we;
                unique case (dec_kind)
                    K_PTR: begin
                        if (bus_we) ptr_wr_v[dec_port] = 1'b1;
                        rd_next = 32'(ptr_a[dec_port]);
                    end
                    K_PROG, K_DATA: begin
                        sel_data_n = (dec_kind == K_DATA);
                        if (in_data != sel_data_n) begin
                            fault_v[dec_port] = 1'b1;
                            fault_bits        = sel_data_n ? 2'b10 : 2'b01;
                        end else begin
                            mem_req[dec_port] = 1'b1;
                            mem_we            = bus_we;
                            if (sel_data_n)
                                mem_wdata = PW'(bus_wdata[DW-1:0]);
                            if (bus_we) begin
                                adv_v[dec_port] = 1'b1;
                            end else begin
                                nxt     = ST_WAIT1;
                                load_rd = 1'b0;
                            end
                        end
                    end
                    K_FSTAT: begin
                        if (bus_we) clr_v[dec_port] = bus_wdata[1:0];
                        rd_next = 32'(fstat_a[dec_port]);
                    end
                    K_FADDR: rd_next = 32'(faddr_a[dec_port]);
                    default: rd_next = '0;
                endcase
            end
            ST_WAIT1: nxt = ST_WAIT2;
            ST_WAIT2: begin
                nxt          = ST_ACK;
                adv_v[sel_q] = 1'b1;
                load_rd      = 1'b1;
                rd_next      = sel_data_q ? 32'(mem_rdata[sel_q*PW +: DW])
                                          : 32'(mem_rdata[sel_q*PW +: PW]);
            end
            ST_ACK: begin
                bus_ready = 1'b1;
                nxt       = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign bus_rdata = rdata_q;

    // R10: one memory strobe at most
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_req));
    // R5: completion is a single-cycle pulse
    a_r5_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    // R5: a memory read completes exactly three cycles after its strobe
    a_r5_read_three: assert property (@(posedge clk) disable iff (!rst_n)
        ((|mem_req) && !mem_we) |-> ##3 bus_ready);
    // R8: a faulting access never reaches memory
    a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (|fault_v) |-> !(|mem_req));
    // R1: memory is never strobed while the bus completes
    a_r1_quiet_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> !(|mem_req));

endmodule

// File: tb/idma_bridge_tb_top.sv
module idma_bridge_tb_top;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_req = 0, bus_we = 0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [1:0]  mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [63:0] mem_rdata;

    int n_checks = 0, n_fail = 0;

    always #5 clk = ~clk;

    idma_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // behavioural memories: 64 words each, two-stage read pipe
    logic [31:0] ram_p [2][64];
    logic [15:0] ram_d [2][64];
    logic [31:0] pipe1 [2];
    logic [31:0] pipe2 [2];
    logic        upper_bad = 0;
    logic        wdata_bad = 0;

    always @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (mem_req[p]) begin
                if (mem_we) begin
                    if (mem_addr < 16'h4000) begin
                        ram_p[p][mem_addr[5:0]] <= mem_wdata;
                        if (mem_wdata != last_wd) wdata_bad <= 1'b1;
                    end else begin
                        ram_d[p][mem_addr[5:0]] <= mem_wdata[15:0];
                        if (mem_wdata[31:16] != 16'h0) upper_bad <= 1'b1;
                    end
                end else begin
                    pipe1[p] <= (mem_addr < 16'h4000) ? ram_p[p][mem_addr[5:0]]
                                                      : {16'hFFFF, ram_d[p][mem_addr[5:0]]};
                end
            end
            pipe2[p] <= pipe1[p];
        end
    end
    assign mem_rdata = {pipe2[1], pipe2[0]};

    logic [31:0] last_wd = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic we, input logic [5:0] off, input logic [31:0] wd,
                       output logic [31:0] rd, output int lat);
        @(negedge clk);
        bus_req = 1; bus_we = we; bus_addr = off; bus_wdata = wd; last_wd = wd;
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (bus_ready) break;
            if (lat > 40) begin
                n_fail++;
                $display("FAIL R5: actual no ready expected ready");
                break;
            end
        end
        rd = bus_rdata;
        bus_req = 0;
    endtask

    function automatic logic [31:0] pval(int p, int i);
        return 32'hC3000000 ^ (32'(p) << 20) ^ (32'(i) * 32'h00010203);
    endfunction

    function automatic logic [31:0] dval(int p, int i);
        return 32'h7E000000 | (32'(p) << 12) | 32'(i * 37 + 5);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int lat;
        logic [5:0] pb;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(bus_ready), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        rst_n = 1;
        for (int p = 0; p < 2; p++) begin
            bus(0, 6'(p*16), 0, rd, lat); chk("R1 ptr", rd, 0);
            bus(0, 6'(32+p*8), 0, rd, lat); chk("R1 fstat", rd, 0);
            bus(0, 6'(36+p*8), 0, rd, lat); chk("R1 faddr", rd, 0);
        end
        // R2 pointer map and readback, R10 independence
        bus(1, 6'h00, 32'h1234, rd, lat); chk("R5 write latency", 32'(lat), 1);
        bus(1, 6'h10, 32'h4321, rd, lat);
        bus(0, 6'h00, 0, rd, lat); chk("R2 ptr0", rd, 32'h1234);
        bus(0, 6'h10, 0, rd, lat); chk("R2 ptr1", rd, 32'h4321);

        for (int p = 0; p < 2; p++) begin
            pb = 6'(p*16);
            // program burst up to the boundary (R3, R7)
            bus(1, pb, 32'h3FFC, rd, lat);
            for (int i = 0; i < 4; i++) begin
                bus(1, pb+4, pval(p, i), rd, lat); chk("R5 prog write lat", 32'(lat), 1);
            end
            chk("R3 wdata full width", 32'(wdata_bad), 0);
            bus(0, pb, 0, rd, lat); chk("R7 ptr after burst", rd, 32'h4000);
            // R8 program window in data space
            bus(1, pb+4, 32'hDEAD, rd, lat); chk("R8 fault lat", 32'(lat), 1);
            bus(0, pb, 0, rd, lat); chk("R8 ptr held", rd, 32'h4000);
            bus(0, 6'(32+p*8), 0, rd, lat); chk("R8 bit0", rd, 1);
            bus(0, 6'(36+p*8), 0, rd, lat); chk("R8 faddr", rd, 32'h4000);
            // data burst (R4, R6)
            for (int i = 0; i < 8; i++) bus(1, pb+8, dval(p, i), rd, lat);
            chk("R4 upper zero", 32'(upper_bad), 0);
            bus(1, pb, 32'h4000, rd, lat);
            for (int i = 0; i < 8; i++) begin
                bus(0, pb+8, 0, rd, lat);
                chk("R6 data read", rd, dval(p, i) & 32'hFFFF);
                chk("R5 read latency", 32'(lat), 3);
            end
            // program readback (R3)
            bus(1, pb, 32'h3FFC, rd, lat);
            for (int i = 0; i < 4; i++) begin
                bus(0, pb+4, 0, rd, lat); chk("R3 prog read", rd, pval(p, i));
            end
            // R8 data window in program space
            bus(1, pb, 32'h3FFF, rd, lat);
            bus(0, pb+8, 0, rd, lat); chk("R8 read zero", rd, 0);
            chk("R8 read fault lat", 32'(lat), 1);
            bus(0, pb, 0, rd, lat); chk("R8 ptr held d", rd, 32'h3FFF);
            bus(0, 6'(32+p*8), 0, rd, lat); chk("R8 bits", rd, 3);
            bus(0, 6'(36+p*8), 0, rd, lat); chk("R8 faddr d", rd, 32'h3FFF);
            // R9 write-one-to-clear and ignored fault address write
            bus(1, 6'(32+p*8), 1, rd, lat);
            bus(0, 6'(32+p*8), 0, rd, lat); chk("R9 w1c bit0", rd, 2);
            bus(1, 6'(36+p*8), 32'h55, rd, lat);
            bus(0, 6'(36+p*8), 0, rd, lat); chk("R9 faddr ro", rd, 32'h3FFF);
            bus(1, 6'(32+p*8), 3, rd, lat);
            bus(0, 6'(32+p*8), 0, rd, lat); chk("R9 clear all", rd, 0);
        end
        // R10 other port untouched by port 0 activity
        bus(1, 6'h10, 32'h0020, rd, lat);
        bus(1, 6'h00, 32'h0010, rd, lat);
        for (int i = 0; i < 3; i++) begin
            bus(1, 6'h04, pval(2, i), rd, lat);
            bus(1, 6'h14, pval(3, i), rd, lat);
        end
        bus(0, 6'h00, 0, rd, lat); chk("R10 ptr0", rd, 32'h0013);
        bus(0, 6'h10, 0, rd, lat); chk("R10 ptr1", rd, 32'h0023);
        bus(1, 6'h10, 32'h0020, rd, lat);
        bus(1, 6'h00, 32'h0010, rd, lat);
        for (int i = 0; i < 3; i++) begin
            bus(0, 6'h14, 0, rd, lat); chk("R10 p1 data", rd, pval(3, i));
            bus(0, 6'h04, 0, rd, lat); chk("R10 p0 data", rd, pval(2, i));
        end
        // R7 wrap
        bus(1, 6'h00, 32'hFFFF, rd, lat);
        bus(1, 6'h08, 32'h9ABC, rd, lat);
        bus(0, 6'h00, 0, rd, lat); chk("R7 wrap", rd, 0);
        bus(1, 6'h08, 32'h1, rd, lat);
        bus(0, 6'h20, 0, rd, lat); chk("R7 wrap fault", rd, 2);
        bus(0, 6'h24, 0, rd, lat); chk("R7 wrap faddr", rd, 0);
        bus(1, 6'h00, 32'hFFFF, rd, lat);
        bus(0, 6'h08, 0, rd, lat); chk("R7 wrap data", rd, 32'h9ABC);
        // R11 unmapped offsets
        bus(1, 6'h0C, 32'hFFFF_FFFF, rd, lat);
        bus(1, 6'h1C, 32'h0, rd, lat);
        bus(1, 6'h3C, 32'h3, rd, lat);
        bus(0, 6'h0C, 0, rd, lat); chk("R11 read zero", rd, 0);
        bus(0, 6'h31, 0, rd, lat); chk("R11 unaligned zero", rd, 0);
        bus(0, 6'h00, 0, rd, lat); chk("R11 ptr0 kept", rd, 0);
        bus(0, 6'h10, 0, rd, lat); chk("R11 ptr1 kept", rd, 32'h0023);
        bus(0, 6'h20, 0, rd, lat); chk("R11 fstat kept", rd, 2);
        @(negedge clk);
        chk("R1 idle strobe", 32'(mem_req), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule